// File: doc/BRIEF.md
# Floating-Point Status and Compare Record Register

This block is the 32-bit status and control word that sits next to a floating-point datapath. It does none of the arithmetic. It holds the control fields the datapath reads, which are the rounding mode and the flush-to-zero enable, and presents them on dedicated outputs. When an operation completes, the block gathers that operation's exception flags into sticky bits. When one of those flags has its enable bit set, the block raises an assist trap.

Compare instructions report their outcome through a separate strobe. The block takes the relation the comparator found and a condition mask, and reduces them to one true/false bit. A nonzero target index writes that bit into a chosen compare bit. A zero index pushes it into a current-compare bit, and the previous current bit moves into the head of a ten-entry history queue. Software can overwrite the whole word through a write port, and a write wins over every other update in the same cycle.

Top module: `fpsr_unit`

## Requirements
- R1: After reset, `status` is zero and `assist_trap`, `round_mode` and `flush_zero` are all zero.
- R2: `round_mode` reflects status bits 10:9 with this encoding: 0 is nearest-even, 1 is toward zero, 2 is toward +infinity, 3 is toward -infinity.
- R3: `flush_zero` equals status bit 5.
- R4: On `op_done`, `op_flags` bits 0..4 (inexact, underflow, overflow, divide-by-zero, invalid) are OR-ed into status bits 27..31 in that order, and a set bit stays set until a write clears it.
- R5: `assist_trap` is high for exactly the one cycle after an `op_done` in which some flag in `op_flags` is set and the enable bit at the same position in status bits 4:0 is also set.
- R6: An `op_done` with all flags zero changes no status bit and raises no trap.
- R7: On `cmp_done` with nonzero `cmp_target` y, the compare bit is written to status bit 22-y, and no other status bit changes.
- R8: On `cmp_done` with `cmp_target` zero, bits 21:12 move to bits 20:11, old bit 26 moves to bit 21, and the compare bit is written to bit 26.
- R9: The compare bit is `cmp_cond` bit 4 for relation code 0 (greater), bit 3 for code 1 (less), bit 2 for code 2 (equal), and bit 1 for code 3 (unordered).
- R10: When `op_done` and `cmp_done` arrive in the same cycle, the flags are folded in first and the compare result is recorded in the same update. Both effects appear together.
- R11: A `wr_en` cycle loads `wr_data` exactly, discards any flag or compare update and trap in that cycle, and `round_mode` and `flush_zero` follow the written value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Direct write strobe |
| wr_data | input | 32 | Value loaded on a write |
| op_done | input | 1 | Operation-complete strobe |
| op_flags | input | 5 | Exception flags of the completed operation |
| cmp_done | input | 1 | Compare-complete strobe |
| cmp_rel | input | 2 | Relation found: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_cond | input | 5 | Condition mask; bit 0 chooses a signalling compare in the datapath |
| cmp_target | input | 3 | Target compare bit index, 0 selects the queue |
| status | output | 32 | Current register value |
| round_mode | output | 2 | Decoded rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |
| assist_trap | output | 1 | One-cycle assist-trap pulse |

## Verification
The assertions check several rules on every cycle. The control outputs track the register. A write loads its data. Sticky flags never clear without a write. A trap never follows a write or an idle cycle. A targeted compare touches only its one bit. The queue shift moves each bit into its neighbour. Some behaviours can only be shown by the bench's scenarios. These are the exact flag-to-bit mapping, the choice of condition bit for each relation, the trap firing only when the flag and enable positions match, and the ordering of a compare that raises flags. The bench shows them with directed sequences and with a randomized run compared against its own model.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int SR_W      = 32;
  localparam int NFLAG     = 5;
  localparam int FLAG_LSB  = SR_W - NFLAG;   // sticky field 31:27
  localparam int RM_LSB    = 9;
  localparam int FTZ_BIT   = 5;
  localparam int CUR_BIT   = 26;
  localparam int QHEAD     = 21;
  localparam int QLEN      = 10;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  // condition mask bit that decides truth for a given relation
  function automatic logic cond_hit(input logic [4:0] cond, input rel_e rel);
    case (rel)
      REL_GT:  cond_hit = cond[4];
      REL_LT:  cond_hit = cond[3];
      REL_EQ:  cond_hit = cond[2];
      default: cond_hit = cond[1];
    endcase
  endfunction
endpackage

// File: rtl/fpsr_ctrl_decode.sv
module fpsr_ctrl_decode
  import fpsr_pkg::*;
(
  input  logic [SR_W-1:0] sr,
  output rmode_e          rm,
  output logic            ftz
);
  always_comb begin
    rm  = rmode_e'(sr[RM_LSB +: 2]);
    ftz = sr[FTZ_BIT];
  end
endmodule

// File: rtl/fpsr_exc_fold.sv
module fpsr_exc_fold
  import fpsr_pkg::*;
(
  input  logic [SR_W-1:0]  cur,
  input  logic             op_done,
  input  logic [NFLAG-1:0] flags,
  output logic [SR_W-1:0]  nxt,
  output logic             trap_evt
);
  logic [NFLAG-1:0] raised;
  logic [NFLAG-1:0] armed;

  assign raised = op_done ? flags : '0;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign armed[i] = raised[i] & cur[i];
  end

  always_comb begin
    nxt = cur;
    nxt[FLAG_LSB +: NFLAG] = cur[FLAG_LSB +: NFLAG] | raised;
  end

  assign trap_evt = |armed;
endmodule

// File: rtl/fpsr_cmp_record.sv
module fpsr_cmp_record
  import fpsr_pkg::*;
#(
  parameter int TGT_W = 3
) (
  input  logic [SR_W-1:0]  cur,
  input  logic             cmp_done,
  input  rel_e             rel,
  input  logic [4:0]       cond,
  input  logic [TGT_W-1:0] tgt,
  output logic [SR_W-1:0]  nxt,
  output logic             cmp_bit
);
  localparam int TOP_IDX = QHEAD + 1;

  assign cmp_bit = cond_hit(cond, rel);

  always_comb begin
    nxt = cur;
    if (cmp_done) begin
      if (tgt != '0) begin
        nxt[TOP_IDX - int'(tgt)] = cmp_bit;
      end else begin
        nxt[QHEAD-1 -: QLEN] = cur[QHEAD -: QLEN];
        nxt[QHEAD]           = cur[CUR_BIT];
        nxt[CUR_BIT]         = cmp_bit;
      end
    end
  end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
#(
  parameter int TGT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             op_done,
  input  logic [4:0]       op_flags,
  input  logic             cmp_done,
  input  logic [1:0]       cmp_rel,
  input  logic [4:0]       cmp_cond,
  input  logic [TGT_W-1:0] cmp_target,
  output logic [31:0]      status,
  output logic [1:0]       round_mode,
  output logic             flush_zero,
  output logic             assist_trap
);
  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_folded;
  logic [SR_W-1:0] sr_next;
  logic            trap_evt;
  logic            cmp_bit;
  rmode_e          rm;

  fpsr_exc_fold u_fold (
    .cur      (sr_q),
    .op_done  (op_done),
    .flags    (op_flags),
    .nxt      (sr_folded),
    .trap_evt (trap_evt)
  );

  fpsr_cmp_record #(.TGT_W(TGT_W)) u_cmp (
    .cur      (sr_folded),
    .cmp_done (cmp_done),
    .rel      (rel_e'(cmp_rel)),
    .cond     (cmp_cond),
    .tgt      (cmp_target),
    .nxt      (sr_next),
    .cmp_bit  (cmp_bit)
  );

  fpsr_ctrl_decode u_dec (
    .sr  (sr_q),
    .rm  (rm),
    .ftz (flush_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q        <= '0;
      assist_trap <= 1'b0;
    end else if (wr_en) begin
      sr_q        <= wr_data;
      assist_trap <= 1'b0;
    end else begin
      sr_q        <= sr_next;
      assist_trap <= trap_evt;
    end
  end

  assign status     = sr_q;
  assign round_mode = rm;
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk #(
  parameter int TGT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic             op_done,
  input logic             cmp_done,
  input logic [TGT_W-1:0] cmp_target,
  input logic [31:0]      status,
  input logic [1:0]       round_mode,
  input logic             flush_zero,
  input logic             assist_trap,
  input logic             trap_evt
);
  // R2
  rm_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_mode == status[10:9]);

  // R3
  ftz_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_zero == status[5]);

  // R11
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status == $past(wr_data));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (status[31:27] & $past(status[31:27])) == $past(status[31:27]));

  // R5
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || !op_done) |=> !assist_trap);

  // R5
  trap_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && trap_evt) |=> assist_trap);

  // R6
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !op_done && !cmp_done) |=> $stable(status));

  // R7
  target_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !op_done && cmp_done && cmp_target != '0) |=>
      ((status ^ $past(status)) & ~(32'h1 << (22 - int'($past(cmp_target))))) == 32'h0);

  // R8
  queue_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cmp_done && cmp_target == '0) |=>
      (status[20:11] == $past(status[21:12])) && (status[21] == $past(status[26])));
endmodule

bind fpsr_unit fpsr_unit_chk #(.TGT_W(TGT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .op_done     (op_done),
  .cmp_done    (cmp_done),
  .cmp_target  (cmp_target),
  .status      (status),
  .round_mode  (round_mode),
  .flush_zero  (flush_zero),
  .assist_trap (assist_trap),
  .trap_evt    (trap_evt)
);

// File: tb/sim_fpsr_unit.sv
`timescale 1ns/1ps
module sim_fpsr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        cmp_done = 1'b0;
  logic [1:0]  cmp_rel = '0;
  logic [4:0]  cmp_cond = '0;
  logic [2:0]  cmp_target = '0;
  logic [31:0] status;
  logic [1:0]  round_mode;
  logic        flush_zero;
  logic        assist_trap;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  logic model_on = 1'b0;

  always #2.5 clk = ~clk;

  fpsr_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_flags(op_flags), .cmp_done(cmp_done),
    .cmp_rel(cmp_rel), .cmp_cond(cmp_cond), .cmp_target(cmp_target),
    .status(status), .round_mode(round_mode), .flush_zero(flush_zero),
    .assist_trap(assist_trap)
  );

  // behavioural reference
  logic [31:0] m_sr = '0;
  logic        m_trap = 1'b0;

  always @(posedge clk) begin
    logic [31:0] s;
    logic        hit;
    logic        c;
    s = m_sr;
    hit = 1'b0;
    if (!rst_n) begin
      m_sr <= '0; m_trap <= 1'b0;
    end else if (wr_en) begin
      m_sr <= wr_data; m_trap <= 1'b0;
    end else begin
      if (op_done) begin
        for (int i = 0; i < 5; i++) begin
          if (op_flags[i]) begin
            s[27 + i] = 1'b1;
            if (m_sr[i]) hit = 1'b1;
          end
        end
      end
      if (cmp_done) begin
        c = (cmp_rel == 2'd0) ? cmp_cond[4] :
            (cmp_rel == 2'd1) ? cmp_cond[3] :
            (cmp_rel == 2'd2) ? cmp_cond[2] : cmp_cond[1];
        if (cmp_target != 0) begin
          s[22 - cmp_target] = c;
        end else begin
          for (int k = 11; k <= 20; k++) s[k] = m_sr[k + 1];
          s[21] = m_sr[26];
          s[26] = c;
        end
      end
      m_sr <= s; m_trap <= hit;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare on every cycle against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk({cur_req, " status"}, status, m_sr);
      chk({cur_req, " trap"}, {31'b0, assist_trap}, {31'b0, m_trap});
      chk("R2 mode", {30'b0, round_mode}, {30'b0, m_sr[10:9]});
      chk("R3 ftz", {31'b0, flush_zero}, {31'b0, m_sr[5]});
    end
  end

  task automatic idle_inputs();
    wr_en = 0; op_done = 0; cmp_done = 0; op_flags = 0;
    cmp_rel = 0; cmp_cond = 0; cmp_target = 0; wr_data = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); idle_inputs(); wr_en = 1; wr_data = d;
    @(negedge clk); idle_inputs();
  endtask

  task automatic op(input logic [4:0] f);
    @(negedge clk); idle_inputs(); op_done = 1; op_flags = f;
    @(negedge clk); idle_inputs();
  endtask

  task automatic cmp(input logic [1:0] r, input logic [4:0] cd, input logic [2:0] t);
    @(negedge clk); idle_inputs(); cmp_done = 1; cmp_rel = r; cmp_cond = cd; cmp_target = t;
    @(negedge clk); idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h0);
    chk("R1 trap", {31'b0, assist_trap}, 32'h0);
    chk("R1 mode", {30'b0, round_mode}, 32'h0);
    model_on = 1;

    cur_req = "R11";
    wr(32'h0000_0620);
    chk("R2 mode toward -inf", {30'b0, round_mode}, 32'd3);
    chk("R3 ftz set", {31'b0, flush_zero}, 32'd1);
    wr(32'h0000_0200);
    chk("R2 mode toward zero", {30'b0, round_mode}, 32'd1);
    chk("R3 ftz clear", {31'b0, flush_zero}, 32'd0);

    cur_req = "R4";
    wr(32'h0);
    op(5'b00101);
    chk("R4 inexact+overflow", status, 32'h2800_0000);
    chk("R4 no trap", {31'b0, assist_trap}, 32'd0);
    op(5'b00010);
    chk("R4 sticky", status, 32'h3800_0000);

    cur_req = "R5";
    wr(32'h0000_0008);
    op(5'b01000);
    chk("R5 trap pulse", {31'b0, assist_trap}, 32'd1);
    chk("R5 status", status, 32'h4000_0008);
    cur_req = "R6";
    op(5'b00000);
    chk("R6 unchanged", status, 32'h4000_0008);
    chk("R6 trap low", {31'b0, assist_trap}, 32'd0);
    cur_req = "R5";
    op(5'b00001);
    chk("R5 unmatched enable", {31'b0, assist_trap}, 32'd0);
    chk("R5 status", status, 32'h4800_0008);

    cur_req = "R7";
    wr(32'h0);
    cmp(2'd2, 5'b00100, 3'd3);
    chk("R7 R9 target 3 equal", status, 32'h0008_0000);
    cmp(2'd0, 5'b00100, 3'd1);
    chk("R9 greater not in mask", status, 32'h0008_0000);
    cmp(2'd0, 5'b10000, 3'd1);
    chk("R7 target 1", status, 32'h0028_0000);

    cur_req = "R8";
    wr(32'h0);
    cmp(2'd1, 5'b01000, 3'd0);
    chk("R8 push 1", status, 32'h0400_0000);
    cmp(2'd3, 5'b01000, 3'd0);
    chk("R8 push 0", status, 32'h0020_0000);
    cmp(2'd3, 5'b00010, 3'd0);
    chk("R8 shift", status, 32'h0410_0000);

    cur_req = "R10";
    wr(32'h0000_0010);
    @(negedge clk); idle_inputs();
    op_done = 1; op_flags = 5'b10000;
    cmp_done = 1; cmp_rel = 2'd3; cmp_cond = 5'b00011; cmp_target = 0;
    @(negedge clk); idle_inputs();
    chk("R10 both applied", status, 32'h8400_0010);
    chk("R10 trap", {31'b0, assist_trap}, 32'd1);

    cur_req = "R11";
    @(negedge clk); idle_inputs();
    wr_en = 1; wr_data = 32'h0000_0400;
    op_done = 1; op_flags = 5'b11111; cmp_done = 1; cmp_cond = 5'b11110;
    @(negedge clk); idle_inputs();
    chk("R11 write wins", status, 32'h0000_0400);
    chk("R11 no trap", {31'b0, assist_trap}, 32'd0);
    chk("R11 R2 mode up", {30'b0, round_mode}, 32'd2);

    cur_req = "R10 random";
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      idle_inputs();
      wr_en = ($urandom_range(0, 15) == 0);
      wr_data = $urandom;
      op_done = $urandom_range(0, 1);
      op_flags = 5'($urandom);
      cmp_done = $urandom_range(0, 1);
      cmp_rel = 2'($urandom);
      cmp_cond = 5'($urandom);
      cmp_target = 3'($urandom);
    end
    @(negedge clk); idle_inputs();
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule